// File: doc/BRIEF.md
# Receive Message FIFO with Full-Buffer Policy

This block holds accepted receive frames for a CAN-style controller until the host collects them. The frame path writes one fixed-width message word per strobe. The host reads the oldest word, which is always visible on the read data output, and removes it with a read strobe. The buffer has four slots by default.

A mode input sets what happens when a frame arrives and the buffer is already full. In replace mode, the new word overwrites the most recently stored entry. The older entries and the read position are left alone. In drop mode, the new word is thrown away and the receive flag is not touched.

The block also reports:
- a receive flag,
- full and empty status,
- the occupancy count,
- a sticky overrun bit that records every replacement or drop until the host clears it.

Top module: `rx_msg_fifo`

## Requirements
- R1: After reset the buffer is empty: `empty_o`=1, `full_o`=0, `count_o`=0, `rx_flag_o`=0, `overrun_o`=0.
- R2: A write strobe while not full stores the word and raises `count_o` by one. Words leave in arrival order. `rd_data_o` shows the oldest stored word, and a read strobe advances to the next one.
- R3: `full_o` is 1 exactly when `count_o` equals the depth (4), and `empty_o` is 1 exactly when `count_o` is 0.
- R4: With `ovr_en_i`=1, a write without a read while full replaces only the newest entry. `count_o`, the head word and all older entries stay unchanged.
- R5: With `ovr_en_i`=0, a write without a read while full is discarded. Contents, `count_o` and `rx_flag_o` stay unchanged.
- R6: `rx_flag_o` is set by every stored or replaced word. It is cleared by the read that empties the buffer.
- R7: A simultaneous write and read while full acts as a read followed by a store. `count_o` stays at the depth and `overrun_o` does not set.
- R8: `overrun_o` sets on every replacement or discard and holds until an `ovr_clr_i` strobe. A set in the same cycle as a clear wins.
- R9: A read strobe while empty is ignored. A simultaneous write and read while empty stores the word and leaves `count_o` at 1.
- R10: `rd_data_o` is all zeros while the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ovr_en_i | input | 1 | 1 = replace newest entry when full, 0 = drop |
| wr_i | input | 1 | Message write strobe |
| wr_data_i | input | MSG_W | Message word to store |
| rd_i | input | 1 | Host read (pop) strobe |
| ovr_clr_i | input | 1 | Clears the sticky overrun bit |
| rd_data_o | output | MSG_W | Oldest stored word, zero when empty |
| full_o | output | 1 | Buffer holds DEPTH words |
| empty_o | output | 1 | Buffer holds no word |
| count_o | output | $clog2(DEPTH+1) | Number of stored words |
| rx_flag_o | output | 1 | Receive message flag |
| overrun_o | output | 1 | Sticky overrun status |

## Verification
The buffer is tested in four ways:
- A partial fill and drain shows that arrival order is kept.
- A full buffer is hit with a write in replace mode and again in drop mode. Popping the whole buffer afterwards shows which slot changed, if any.
- A write and a read in the same cycle are applied at both the full and the empty boundary. This separates the read-then-store ordering from the overwrite and discard paths.
- A discard is applied in the same cycle as a clear strobe to check that the set wins.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE,
    ACT_STORE,
    ACT_REPLACE,
    ACT_DROP
  } wr_act_e;
endpackage

// File: rtl/rx_fifo_ctrl.sv
module rx_fifo_ctrl
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ovr_en_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             ovr_clr_i,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic [PTR_W-1:0] rd_addr_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             rx_flag_o,
  output logic             overrun_o
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, newest;
  logic [CNT_W-1:0] count_q;
  logic             flag_q, ovr_q;
  logic             push_ok, pop_ok;
  wr_act_e          act;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (count_q == CNT_FULL);
  assign empty_o = (count_q == '0);
  assign newest  = (wr_ptr_q == '0) ? LAST_IDX : wr_ptr_q - 1'b1;

  // read frees a slot first, so write+read while full is a plain store
  always_comb begin
    act = ACT_IDLE;
    if (wr_i) begin
      if (!full_o || rd_i) act = ACT_STORE;
      else if (ovr_en_i)   act = ACT_REPLACE;
      else                 act = ACT_DROP;
    end
  end

  assign push_ok   = (act == ACT_STORE);
  assign pop_ok    = rd_i && !empty_o;
  assign wr_en_o   = push_ok || (act == ACT_REPLACE);
  assign wr_addr_o = (act == ACT_REPLACE) ? newest : wr_ptr_q;
  assign rd_addr_o = rd_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (wr_en_o)                                 flag_q <= 1'b1;
      else if (pop_ok && count_q == CNT_W'(1))     flag_q <= 1'b0;
      if (act == ACT_REPLACE || act == ACT_DROP)   ovr_q  <= 1'b1;
      else if (ovr_clr_i)                          ovr_q  <= 1'b0;
    end
  end

  assign count_o   = count_q;
  assign rx_flag_o = flag_q;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/rx_fifo_store.sv
module rx_fifo_store #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned MSG_W = 32,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_addr_i,
  input  logic [MSG_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0] rd_addr_i,
  input  logic             empty_i,
  output logic [MSG_W-1:0] rd_data_o
);
  logic [MSG_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_addr_i == PTR_W'(g)) slot_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = empty_i ? '0 : slot_q[rd_addr_i];
endmodule

// File: rtl/rx_msg_fifo.sv
module rx_msg_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned MSG_W = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ovr_en_i,
  input  logic             wr_i,
  input  logic [MSG_W-1:0] wr_data_i,
  input  logic             rd_i,
  input  logic             ovr_clr_i,
  output logic [MSG_W-1:0] rd_data_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] count_o,
  output logic             rx_flag_o,
  output logic             overrun_o
);
  logic             wr_en;
  logic [PTR_W-1:0] wr_addr, rd_addr;

  rx_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ovr_en_i  (ovr_en_i),
    .wr_i      (wr_i),
    .rd_i      (rd_i),
    .ovr_clr_i (ovr_clr_i),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .rd_addr_o (rd_addr),
    .count_o   (count_o),
    .full_o    (full_o),
    .empty_o   (empty_o),
    .rx_flag_o (rx_flag_o),
    .overrun_o (overrun_o)
  );

  rx_fifo_store #(.DEPTH(DEPTH), .MSG_W(MSG_W)) store_i (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr),
    .empty_i   (empty_o),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/rx_msg_fifo_chk.sv
module rx_msg_fifo_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned MSG_W = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ovr_en_i,
  input logic             wr_i,
  input logic             rd_i,
  input logic             ovr_clr_i,
  input logic [MSG_W-1:0] rd_data_o,
  input logic             full_o,
  input logic             empty_o,
  input logic [CNT_W-1:0] count_o,
  input logic             rx_flag_o,
  input logic             overrun_o
);
  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH)) else $error("count above depth"); // R3
  AST_STATUS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o)) else $error("full and empty together"); // R3
  AST_REPLACE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_i && !rd_i && ovr_en_i) |=> (full_o && $stable(count_o) && $stable(rd_data_o)))
    else $error("replace moved head or count"); // R4
  AST_DROP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_i && !rd_i && !ovr_en_i) |=> ($stable(count_o) && $stable(rx_flag_o) && $stable(rd_data_o)))
    else $error("drop changed state"); // R5
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == CNT_W'(1) && rd_i && !wr_i) |=> (!rx_flag_o && empty_o))
    else $error("flag not cleared on last pop"); // R6
  AST_FULL_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_i && rd_i && !overrun_o) |=> (full_o && !overrun_o))
    else $error("simultaneous ops at full misbehaved"); // R7
  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_i && !rd_i) |=> overrun_o) else $error("overrun not set"); // R8
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && rd_i && !wr_i) |=> empty_o) else $error("pop on empty changed state"); // R9
  AST_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (rd_data_o == '0)) else $error("data not zero when empty"); // R10
endmodule

bind rx_msg_fifo rx_msg_fifo_chk #(.DEPTH(DEPTH), .MSG_W(MSG_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ovr_en_i  (ovr_en_i),
  .wr_i      (wr_i),
  .rd_i      (rd_i),
  .ovr_clr_i (ovr_clr_i),
  .rd_data_o (rd_data_o),
  .full_o    (full_o),
  .empty_o   (empty_o),
  .count_o   (count_o),
  .rx_flag_o (rx_flag_o),
  .overrun_o (overrun_o)
);

// File: tb/rx_msg_fifo_tb_top.sv
`timescale 1ns/1ps
module rx_msg_fifo_tb_top;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned MSG_W = 32;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ovr_en = 1'b0, wr = 1'b0, rd = 1'b0, ovr_clr = 1'b0;
  logic [MSG_W-1:0] wr_data = '0;
  logic [MSG_W-1:0] rd_data;
  logic             full, empty, rx_flag, overrun;
  logic [CNT_W-1:0] count;
  int               n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  rx_msg_fifo #(.DEPTH(DEPTH), .MSG_W(MSG_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ovr_en_i(ovr_en), .wr_i(wr), .wr_data_i(wr_data),
    .rd_i(rd), .ovr_clr_i(ovr_clr), .rd_data_o(rd_data), .full_o(full),
    .empty_o(empty), .count_o(count), .rx_flag_o(rx_flag), .overrun_o(overrun)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, sample 1ns after the next posedge
  task automatic step(input logic w, input logic [31:0] d, input logic r, input logic c);
    @(negedge clk);
    wr = w; wr_data = d; rd = r; ovr_clr = c;
    @(posedge clk); #1;
    wr = 1'b0; rd = 1'b0; ovr_clr = 1'b0;
  endtask

  task automatic drain_expect(input string tag, input logic [31:0] first, input logic [31:0] last);
    for (int i = 0; i < 3; i++) begin
      chk(tag, rd_data, first + i);
      step(1'b0, 0, 1'b1, 1'b0);
    end
    chk(tag, rd_data, last);
    step(1'b0, 0, 1'b1, 1'b0);
    chk({tag, " empty"}, {31'b0, empty}, 1);
  endtask

  task automatic t_reset();
    chk("R1 empty", {31'b0, empty}, 1);
    chk("R1 full", {31'b0, full}, 0);
    chk("R1 count", {29'b0, count}, 0);
    chk("R1 flag", {31'b0, rx_flag}, 0);
    chk("R1 overrun", {31'b0, overrun}, 0);
    chk("R10 data zero", rd_data, 0);
  endtask

  task automatic t_order();
    step(1'b1, 32'hA1, 1'b0, 1'b0);
    chk("R6 flag set", {31'b0, rx_flag}, 1);
    step(1'b1, 32'hA2, 1'b0, 1'b0);
    step(1'b1, 32'hA3, 1'b0, 1'b0);
    chk("R2 count", {29'b0, count}, 3);
    chk("R3 not full", {31'b0, full}, 0);
    chk("R2 head", rd_data, 32'hA1);
    step(1'b0, 0, 1'b1, 1'b0);
    chk("R2 second", rd_data, 32'hA2);
    step(1'b0, 0, 1'b1, 1'b0);
    chk("R2 third", rd_data, 32'hA3);
    chk("R6 flag held", {31'b0, rx_flag}, 1);
    step(1'b0, 0, 1'b1, 1'b0);
    chk("R3 empty", {31'b0, empty}, 1);
    chk("R6 flag cleared", {31'b0, rx_flag}, 0);
    chk("R10 data zero", rd_data, 0);
  endtask

  task automatic t_replace();
    ovr_en = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b1, 32'h10 + i, 1'b0, 1'b0);
    chk("R3 full", {31'b0, full}, 1);
    step(1'b1, 32'h99, 1'b0, 1'b0);
    chk("R4 count", {29'b0, count}, 4);
    chk("R4 head", rd_data, 32'h10);
    chk("R8 overrun set", {31'b0, overrun}, 1);
    drain_expect("R4 contents", 32'h10, 32'h99);
    chk("R8 overrun sticky", {31'b0, overrun}, 1);
    step(1'b0, 0, 1'b0, 1'b1);
    chk("R8 overrun cleared", {31'b0, overrun}, 0);
  endtask

  task automatic t_drop();
    ovr_en = 1'b0;
    for (int i = 0; i < 4; i++) step(1'b1, 32'h20 + i, 1'b0, 1'b0);
    step(1'b1, 32'h77, 1'b0, 1'b0);
    chk("R5 count", {29'b0, count}, 4);
    chk("R5 flag unchanged", {31'b0, rx_flag}, 1);
    chk("R8 overrun set", {31'b0, overrun}, 1);
    drain_expect("R5 contents", 32'h20, 32'h23);
    chk("R6 flag cleared", {31'b0, rx_flag}, 0);
    step(1'b0, 0, 1'b0, 1'b1);
  endtask

  task automatic t_full_swap();
    ovr_en = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b1, 32'h30 + i, 1'b0, 1'b0);
    step(1'b1, 32'h55, 1'b1, 1'b0);
    chk("R7 count", {29'b0, count}, 4);
    chk("R7 no overrun", {31'b0, overrun}, 0);
    drain_expect("R7 contents", 32'h31, 32'h55);
  endtask

  task automatic t_empty_ops();
    step(1'b0, 0, 1'b1, 1'b0);
    chk("R9 pop empty count", {29'b0, count}, 0);
    chk("R9 pop empty flag", {31'b0, empty}, 1);
    step(1'b1, 32'h66, 1'b1, 1'b0);
    chk("R9 push+pop count", {29'b0, count}, 1);
    chk("R9 push+pop head", rd_data, 32'h66);
    chk("R6 flag set", {31'b0, rx_flag}, 1);
    step(1'b0, 0, 1'b1, 1'b0);
  endtask

  task automatic t_clr_race();
    ovr_en = 1'b0;
    for (int i = 0; i < 4; i++) step(1'b1, 32'h40 + i, 1'b0, 1'b0);
    step(1'b1, 32'h88, 1'b0, 1'b1);
    chk("R8 set beats clear", {31'b0, overrun}, 1);
    step(1'b0, 0, 1'b0, 1'b1);
    chk("R8 clear", {31'b0, overrun}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_order();
    t_replace();
    t_drop();
    t_full_swap();
    t_empty_ops();
    t_clr_race();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule